// File: doc/BRIEF.md
# Branch Direction Predictor Table

This block sits in the fetch stage and guesses whether the branch at the current fetch address will be taken. It is a table of small history entries. The entry is chosen by the low-order bits of the word address, and the guess comes back combinationally in the same cycle as the address. Entries carry no tag. Two branches whose addresses agree in the index bits share one entry, and each disturbs the other's history. That costs accuracy but never correctness.

Once a branch resolves later in the pipeline, its address, its actual direction and a valid strobe arrive on the update port. In that same cycle the block compares the stored guess for that address with the actual outcome and raises a mispredict flag when they differ. On the next clock edge it rewrites the entry.

A parameter chooses the entry format when the block is elaborated. One choice is a single bit that remembers the last outcome. The other is a two-bit saturating counter, which has to be wrong twice in a row before its guess flips. That second choice suits loop branches, which fall through once per trip.

Top module: `branch_hist_predictor`

## Requirements
- R1: After reset, every entry predicts not-taken (`pred_taken` = 0 for any address) and `upd_mispredict` stays 0 for an update whose outcome is not-taken.
- R2: The entry index is address bits [IDX_W+1:2], where IDX_W = log2(ENTRIES). Addresses that differ only in bits [1:0], or only in bits above the index, select the same entry.
- R3: With HIST_BITS = 1, a valid update stores the actual outcome. A misprediction therefore inverts the entry, and a correct prediction leaves it unchanged.
- R4: With HIST_BITS = 2, the entry is a counter in which 0 and 1 predict not-taken and 2 and 3 predict taken. A taken update adds one and a not-taken update subtracts one, and the counter saturates at 0 and at 3.
- R5: With HIST_BITS = 2, an entry in a strong state (0 or 3) keeps its predicted direction after one misprediction and changes direction only after a second consecutive one.
- R6: `upd_mispredict` is high in the same cycle as `upd_valid` exactly when the entry's current prediction for `upd_pc` differs from `upd_taken`. It is low whenever `upd_valid` is low.
- R7: When `fetch_pc` and a valid update select the same entry in one cycle, `pred_taken` shows the value from before the update. The new value appears from the following cycle.
- R8: While `upd_valid` is low, the values on `upd_pc` and `upd_taken` change no entry.
- R9: A loop branch that is taken nine times and then not taken once, repeated, gets 8 of 10 predictions right per trip with HIST_BITS = 1 and 9 of 10 with HIST_BITS = 2 once warmed up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears all entries to not-taken |
| fetch_pc | input | PC_W | Fetch address to predict |
| pred_taken | output | 1 | Predicted direction for `fetch_pc` (1 = taken) |
| upd_valid | input | 1 | A resolved branch is presented on the update port |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch (1 = taken) |
| upd_mispredict | output | 1 | Stored prediction for `upd_pc` disagreed with `upd_taken` |

## Verification
A corrupted or stale entry shows up at the ports as soon as any address that maps to it is looked up. `pred_taken` is wrong in that same cycle, and `upd_mispredict` is wrong as soon as that branch resolves. A counter that steps the wrong way or fails to saturate does not show up at once. It shows up only after the update sequence that pushes the entry across the taken/not-taken boundary, so the directed sequences walk each entry through both strong states and back. Index mistakes show up as two addresses that should alias but disagree, or as two addresses that should be separate but move together.

// File: rtl/bhtp_pkg.sv
package bhtp_pkg;
   // Byte-offset bits dropped from the address before indexing
   localparam int unsigned BYTE_OFS = 2;

   typedef enum logic {
      DIR_NOT_TAKEN = 1'b0,
      DIR_TAKEN     = 1'b1
   } dir_e;
endpackage

// File: rtl/bhtp_index.sv
module bhtp_index
   import bhtp_pkg::*;
#(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned IDX_W = 10
) (
   input  logic [PC_W-1:0]  pc,
   output logic [IDX_W-1:0] idx
);
   // Word index: skip byte offset, take the next IDX_W bits
   assign idx = pc[BYTE_OFS +: IDX_W];
endmodule

// File: rtl/bhtp_next.sv
module bhtp_next #(
   parameter int unsigned HIST_BITS = 2
) (
   input  logic [HIST_BITS-1:0] cur,
   input  logic                 taken,
   output logic [HIST_BITS-1:0] nxt
);
   localparam logic [HIST_BITS-1:0] TOP = {HIST_BITS{1'b1}};
   localparam logic [HIST_BITS-1:0] BOT = '0;

   generate
      if (HIST_BITS == 1) begin : g_last_outcome
         // Single bit simply records the latest direction
         assign nxt = taken;
      end else begin : g_sat_counter
         always_comb begin
            nxt = cur;
            if (taken && (cur != TOP))
               nxt = cur + 1'b1;
            else if (!taken && (cur != BOT))
               nxt = cur - 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/bhtp_table.sv
module bhtp_table #(
   parameter int unsigned ENTRIES   = 1024,
   parameter int unsigned IDX_W     = 10,
   parameter int unsigned HIST_BITS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [IDX_W-1:0]     rd_idx,
   output logic [HIST_BITS-1:0] rd_state,
   input  logic [IDX_W-1:0]     up_idx,
   output logic [HIST_BITS-1:0] up_state,
   input  logic                 wr_en,
   input  logic [HIST_BITS-1:0] wr_state
);
   logic [HIST_BITS-1:0] mem [ENTRIES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++)
            mem[i] <= '0;
      end else if (wr_en) begin
         mem[up_idx] <= wr_state;
      end
   end

   // Both reads see stored state; a same-cycle write lands at the edge
   assign rd_state = mem[rd_idx];
   assign up_state = mem[up_idx];
endmodule

// File: rtl/branch_hist_predictor.sv
module branch_hist_predictor #(
   parameter int unsigned PC_W      = 32,
   parameter int unsigned ENTRIES   = 1024,
   parameter int unsigned HIST_BITS = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] fetch_pc,
   output logic            pred_taken,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_taken,
   output logic            upd_mispredict
);
   import bhtp_pkg::*;

   localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam int unsigned MSB   = HIST_BITS - 1;

   // Elaboration-time configuration checks
   generate
      if (HIST_BITS != 1 && HIST_BITS != 2) begin : g_bad_hist
         $error("HIST_BITS must be 1 or 2");
      end
      if ((1 << IDX_W) != ENTRIES || ENTRIES < 2) begin : g_bad_depth
         $error("ENTRIES must be a power of two, at least 2");
      end
      if (PC_W < IDX_W + BYTE_OFS) begin : g_bad_pcw
         $error("PC_W too narrow for the index");
      end
   endgenerate

   logic [IDX_W-1:0]     fetch_idx, upd_idx;
   logic [HIST_BITS-1:0] fetch_state, upd_state, upd_next;
   dir_e                 upd_dir;

   bhtp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_fidx (
      .pc (fetch_pc),
      .idx(fetch_idx)
   );

   bhtp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_uidx (
      .pc (upd_pc),
      .idx(upd_idx)
   );

   bhtp_next #(.HIST_BITS(HIST_BITS)) u_next (
      .cur  (upd_state),
      .taken(upd_taken),
      .nxt  (upd_next)
   );

   bhtp_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .HIST_BITS(HIST_BITS)) u_tab (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (fetch_idx),
      .rd_state(fetch_state),
      .up_idx  (upd_idx),
      .up_state(upd_state),
      .wr_en   (upd_valid),
      .wr_state(upd_next)
   );

   assign upd_dir        = dir_e'(upd_state[MSB]);
   assign pred_taken     = fetch_state[MSB];
   assign upd_mispredict = upd_valid && (upd_dir != dir_e'(upd_taken));

   // R6: flag only accompanies a valid update
   a_r6_flag_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      upd_mispredict |-> upd_valid);

   // R8: no update strobe, same fetch address -> same prediction
   a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_valid && fetch_idx == upd_idx) |=>
         (!$stable(fetch_pc) || $stable(pred_taken)));

   // R7: same-cycle collision reads the pre-update entry
   a_r7_old_on_collision: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && fetch_idx == upd_idx) |-> (pred_taken == upd_state[MSB]));

   generate
      if (HIST_BITS == 1) begin : g_chk_one
         // R3: entry follows the last resolved outcome
         a_r3_tracks_outcome: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_valid && fetch_idx == upd_idx) |=>
               (!$stable(fetch_pc) || pred_taken == $past(upd_taken)));
      end else begin : g_chk_two
         // R5: a strong entry keeps its direction across one update
         a_r5_strong_keeps_dir: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_valid && fetch_idx == upd_idx &&
             (upd_state == '0 || upd_state == '1)) |=>
               (!$stable(fetch_pc) || pred_taken == $past(pred_taken)));
         // R4: counter flags a mispredict on a weak entry too
         a_r4_weak_flag: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_valid && upd_state == 2'b01 && upd_taken) |-> upd_mispredict);
      end
   endgenerate
endmodule

// File: tb/branch_hist_predictor_tb.sv
module branch_hist_predictor_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] fetch_pc = '0;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_pc = '0;
   logic        upd_taken = 1'b0;
   logic        p2, m2, p1, m1;
   int          total = 0;
   int          bad = 0;
   bit          done = 0;

   always #2 clk = ~clk;

   branch_hist_predictor #(.PC_W(32), .ENTRIES(64), .HIST_BITS(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_taken(p2),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
      .upd_mispredict(m2));

   branch_hist_predictor #(.PC_W(32), .ENTRIES(64), .HIST_BITS(1)) u_dut1 (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_taken(p1),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
      .upd_mispredict(m1));

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic look(input logic [31:0] pc, output logic q1, output logic q2);
      @(negedge clk);
      fetch_pc = pc;
      #1;
      q1 = p1;
      q2 = p2;
   endtask

   task automatic upd(input logic [31:0] pc, input logic t,
                      output logic mp1, output logic mp2);
      @(negedge clk);
      upd_pc = pc; upd_taken = t; upd_valid = 1'b1;
      #1;
      mp1 = m1; mp2 = m2;
      @(posedge clk);
      #1;
      upd_valid = 1'b0;
   endtask

   task automatic t_reset();
      logic a, b;
      for (int k = 0; k < 4; k++) begin
         look(32'h0000_0004 * k * 7, a, b);
         check("R1 one-bit reset pred", a, 0);
         check("R1 two-bit reset pred", b, 0);
      end
      upd(32'h0000_00F0, 1'b0, a, b);
      check("R1 one-bit no mispredict on NT", a, 0);
      check("R1 two-bit no mispredict on NT", b, 0);
   endtask

   task automatic t_one_bit();
      logic a, b, q1, q2;
      upd(32'h04, 1'b1, a, b);
      check("R6 one-bit flag on first taken", a, 1);
      look(32'h04, q1, q2);
      check("R3 inverted to taken", q1, 1);
      upd(32'h04, 1'b1, a, b);
      check("R6 one-bit no flag when right", a, 0);
      look(32'h04, q1, q2);
      check("R3 unchanged when right", q1, 1);
      upd(32'h04, 1'b0, a, b);
      check("R6 one-bit flag on NT", a, 1);
      look(32'h04, q1, q2);
      check("R3 inverted to not-taken", q1, 0);
   endtask

   task automatic t_two_bit();
      logic a, b, q1, q2;
      // entry at 0x08 starts at state 0
      upd(32'h08, 1'b1, a, b);
      check("R6 two-bit flag 0->1", b, 1);
      look(32'h08, q1, q2);
      check("R5 single miss keeps NT", q2, 0);
      upd(32'h08, 1'b1, a, b);
      check("R4 flag on weak NT", b, 1);
      look(32'h08, q1, q2);
      check("R5 second miss flips to T", q2, 1);
      upd(32'h08, 1'b1, a, b);
      check("R4 no flag in state 2 taken", b, 0);
      upd(32'h08, 1'b1, a, b);
      upd(32'h08, 1'b1, a, b);
      upd(32'h08, 1'b0, a, b);
      check("R6 two-bit flag from strong T", b, 1);
      look(32'h08, q1, q2);
      check("R4 saturated high stays T", q2, 1);
      upd(32'h08, 1'b0, a, b);
      look(32'h08, q1, q2);
      check("R5 second NT flips to NT", q2, 0);
      // saturate low at 0x0C
      for (int k = 0; k < 3; k++) upd(32'h0C, 1'b0, a, b);
      upd(32'h0C, 1'b1, a, b);
      look(32'h0C, q1, q2);
      check("R4 saturated low then one T", q2, 0);
      upd(32'h0C, 1'b1, a, b);
      look(32'h0C, q1, q2);
      check("R4 two T from floor gives T", q2, 1);
   endtask

   task automatic t_alias();
      logic a, b, q1, q2;
      upd(32'h40, 1'b1, a, b);
      upd(32'h40, 1'b1, a, b);
      look(32'h43, q1, q2);
      check("R2 byte offset ignored 1b", q1, 1);
      check("R2 byte offset ignored 2b", q2, 1);
      look(32'h140, q1, q2);
      check("R2 upper bits alias 1b", q1, 1);
      check("R2 upper bits alias 2b", q2, 1);
      look(32'h44, q1, q2);
      check("R2 neighbour separate 1b", q1, 0);
      check("R2 neighbour separate 2b", q2, 0);
      upd(32'hFFFF_0140, 1'b0, a, b);
      check("R6 aliased update sees shared entry", a, 1);
   endtask

   task automatic t_collision();
      @(negedge clk);
      fetch_pc = 32'h14;
      upd_pc = 32'h14; upd_taken = 1'b1; upd_valid = 1'b1;
      #1;
      check("R7 old value during update", p1, 0);
      @(posedge clk);
      #1;
      upd_valid = 1'b0;
      check("R7 new value next cycle", p1, 1);
   endtask

   task automatic t_idle();
      @(negedge clk);
      fetch_pc = 32'h18;
      upd_pc = 32'h18; upd_taken = 1'b1; upd_valid = 1'b0;
      for (int k = 0; k < 4; k++) begin
         @(posedge clk);
         #1;
         check("R8 no flag while idle", m1 | m2, 0);
      end
      check("R8 one-bit entry untouched", p1, 0);
      check("R8 two-bit entry untouched", p2, 0);
   endtask

   task automatic t_loop();
      logic a, b;
      int ok1, ok2;
      for (int pass = 0; pass < 3; pass++) begin
         ok1 = 0; ok2 = 0;
         for (int it = 0; it < 10; it++) begin
            upd(32'h28, (it < 9), a, b);
            if (!a) ok1++;
            if (!b) ok2++;
         end
         if (pass == 2) begin
            check("R9 one-bit loop accuracy", ok1, 8);
            check("R9 two-bit loop accuracy", ok2, 9);
         end
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_one_bit();
      t_two_bit();
      t_alias();
      t_collision();
      t_idle();
      t_loop();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule